// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs the serial management protocol toward external PHY devices. It can read or write one 16-bit register per request. A request is a one-cycle start strobe. With the strobe come a direction flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then produces the management clock itself, using a programmable divider on the system clock. It shifts the frame out on the data line and, for a read, collects the PHY's answer. When the transaction ends it raises a one-cycle done pulse.

The bidirectional data line is presented as three separate signals: a driven value, a drive enable and a sampled input. The pad buffer lies outside this block.

A read does not assume the PHY answers at a fixed bit position. After the master lets go of the line, it skips one bit time. It then waits for the PHY to pull the line to 0 and starts capturing data on the bit after that 0. If no 0 appears within a configurable number of clock periods, the transaction is abandoned and flagged as a timeout.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy, done, timeout, mdc and mdio_oe are all 0.
- R2: Every frame starts with 32 bits of 1 on mdio_o, followed by the start pattern 0 then 1.
- R3: The two operation bits that follow are 0,1 for a write (rd_nwr=0) and 1,0 for a read (rd_nwr=1).
- R4: The PHY address is sent next, then the register address, 5 bits each, most significant bit first.
- R5: On a write, the master then drives the turnaround 1,0 and the 16 bits of wr_data, MSB first, for 64 driven bits in total. mdio_oe drops at the falling mdc edge after the last bit, in the same cycle done pulses.
- R6: On a read, the master drives 46 bits and drops mdio_oe at the next falling edge. It ignores the first rising-edge sample after release. It then looks for mdio_i=0 on each of the following TMO_BITS rising edges. The 16 samples after that 0 appear on rd_data, MSB first, with done, and timeout stays 0.
- R7: If none of those TMO_BITS samples is 0, done pulses with timeout=1 and rd_data keeps its previous value. timeout is cleared when the next transaction starts.
- R8: mdc stays high and then low for clk_div+1 system clock cycles each. mdio_o changes only at falling mdc edges while driven. mdc is 0 whenever the block is idle.
- R9: A start pulse while busy is ignored: the frame in flight keeps its own fields, and no second transaction follows. busy stays 1 until the done pulse.
- R10: done is high for exactly one system clock cycle per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write |
| clk_div | input | DIVW | mdc half period minus one, in clk cycles |
| rd_data | output | 16 | Last data read |
| done | output | 1 | One-cycle end-of-transaction pulse |
| timeout | output | 1 | Last read found no sync 0 |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Sampled data line |

## Verification
Frame bits are due on each rising mdc edge. The bench captures them at those edges, which always fall between mdio_o updates at the falling edges. The PHY model changes mdio_i 1 ns after a falling mdc edge, so each value is settled well before the rising edge that samples it. rd_data, timeout, the release of mdio_oe and the return of busy to 0 are all registered in the same cycle as done. The bench polls on falling system clock edges and checks all of these in the cycle where it sees done, then checks that done is low in the next cycle. The sync-0 window is tested at its exact edge: a 0 that arrives TMO_BITS-1 bits late still completes, and one bit later the read times out.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIVW     = 8,
  parameter int TMO_BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            rd_nwr,
  input  logic [4:0]      phy_addr,
  input  logic [4:0]      reg_addr,
  input  logic [15:0]     wr_data,
  input  logic [DIVW-1:0] clk_div,
  output logic [15:0]     rd_data,
  output logic            done,
  output logic            timeout,
  output logic            busy,
  output logic            mdc,
  output logic            mdio_o,
  output logic            mdio_oe,
  input  logic            mdio_i
);
  localparam int TW = $clog2(TMO_BITS + 1);
  localparam logic [5:0] LAST_WR = 6'd63;
  localparam logic [5:0] LAST_RD = 6'd45;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_CAPT} st_t;

  st_t            st;
  logic [DIVW-1:0] dcnt;
  logic [63:0]     sh;
  logic [5:0]      bitn;
  logic            rd_q, skip;
  logic [TW-1:0]   tcnt;
  logic [14:0]     rsh;
  logic [3:0]      ccnt;
  logic            tick, rise, fall;
  logic [5:0]      last;

  assign busy   = (st != S_IDLE);
  assign tick   = busy && (dcnt == clk_div);
  assign rise   = tick && !mdc;
  assign fall   = tick && mdc;
  assign mdio_o = sh[63];
  assign last   = rd_q ? LAST_RD : LAST_WR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      dcnt    <= '0;
      sh      <= '0;
      bitn    <= '0;
      rd_q    <= 1'b0;
      skip    <= 1'b0;
      tcnt    <= '0;
      rsh     <= '0;
      ccnt    <= '0;
      rd_data <= '0;
      done    <= 1'b0;
      timeout <= 1'b0;
      mdc     <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy || tick) dcnt <= '0;
      else               dcnt <= dcnt + 1'b1;
      if (tick) mdc <= ~mdc;

      case (st)
        S_IDLE: begin
          if (start) begin
            st      <= S_SEND;
            sh      <= {32'hFFFF_FFFF, 2'b01, (rd_nwr ? 2'b10 : 2'b01),
                        phy_addr, reg_addr, 2'b10, wr_data};
            rd_q    <= rd_nwr;
            bitn    <= '0;
            mdio_oe <= 1'b1;
            timeout <= 1'b0;
          end
        end
        S_SEND: begin
          if (fall) begin
            if (bitn == last) begin
              mdio_oe <= 1'b0;
              if (rd_q) begin
                st   <= S_WAIT;
                skip <= 1'b1;
                tcnt <= '0;
              end else begin
                st   <= S_IDLE;
                done <= 1'b1;
              end
            end else begin
              sh   <= {sh[62:0], 1'b0};
              bitn <= bitn + 1'b1;
            end
          end
        end
        S_WAIT: begin
          if (rise) begin
            if (skip) begin
              skip <= 1'b0;
            end else if (!mdio_i) begin
              st   <= S_CAPT;
              ccnt <= '0;
            end else if (tcnt == TW'(TMO_BITS - 1)) begin
              st      <= S_IDLE;
              done    <= 1'b1;
              timeout <= 1'b1;
              mdc     <= 1'b0;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        S_CAPT: begin
          if (rise) begin
            rsh  <= {rsh[13:0], mdio_i};
            ccnt <= ccnt + 1'b1;
            if (ccnt == 4'd15) begin
              rd_data <= {rsh, mdio_i};
              st      <= S_IDLE;
              done    <= 1'b1;
              mdc     <= 1'b0;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic timeout,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  a_r8_out_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));

  a_r8_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  a_r5_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r7_timeout_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .timeout(timeout),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
  localparam int TMO = 8;

  logic clk = 0, rst_n = 0, start = 0, rd_nwr = 0, mdio_i = 1;
  logic [4:0] phy_addr = 0, reg_addr = 0;
  logic [15:0] wr_data = 0;
  logic [7:0] clk_div = 0;
  logic [15:0] rd_data;
  logic done, timeout, busy, mdc, mdio_o, mdio_oe;
  int checks = 0, fails = 0;
  logic [15:0] last_rd = 0;

  always #2 clk = ~clk;

  mdio_master #(.DIVW(8), .TMO_BITS(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .clk_div(clk_div), .rd_data(rd_data), .done(done), .timeout(timeout),
    .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, wd};
  endfunction

  task automatic run_txn(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input logic [15:0] rdv, input int lat, input bit poke);
    logic [63:0] got = '0, mask;
    int nb = rd ? 46 : 64;
    bit oe_ok = 1, seen = 0, extra = 0;
    bit exp_to = rd && (lat >= TMO);
    @(negedge clk);
    rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) fork
      begin
        repeat (20) @(negedge clk);
        start = 1; rd_nwr = ~rd; phy_addr = ~pa; wr_data = ~wd;
        @(negedge clk);
        start = 0;
      end
    join_none
    for (int i = 0; i < nb; i++) begin
      @(posedge mdc);
      got = {got[62:0], mdio_o};
      if (!mdio_oe) oe_ok = 0;
    end
    got = got << (64 - nb);
    mask = ~64'h0 << (64 - nb);
    chk(oe_ok, "R2 oe held over frame", 64'(oe_ok), 64'd1);
    chk(got[63:30] == exp_frame(rd, pa, ra, wd) >> 30, "R2 preamble/start", got[63:30], exp_frame(rd, pa, ra, wd) >> 30);
    chk(got[29:28] == (rd ? 2'b10 : 2'b01), "R3 opcode", 64'(got[29:28]), 64'(rd ? 2'b10 : 2'b01));
    chk(got[27:18] == {pa, ra}, "R4 addresses", 64'(got[27:18]), 64'({pa, ra}));
    if (!rd)
      chk((got & mask) == exp_frame(rd, pa, ra, wd), "R5 turnaround and data", got, exp_frame(rd, pa, ra, wd));
    if (rd) begin
      @(negedge mdc); #1;
      chk(!mdio_oe, "R6 release after reg address", 64'(mdio_oe), 64'd0);
      mdio_i = 1;
      for (int k = 0; k < ((lat < TMO) ? lat : TMO); k++) begin
        @(negedge mdc); #1 mdio_i = 1;
      end
      if (!exp_to) begin
        @(negedge mdc); #1 mdio_i = 0;
        for (int j = 0; j < 16; j++) begin
          @(negedge mdc); #1 mdio_i = rdv[15-j];
        end
      end
    end
    for (int c = 0; c < 20000 && !seen; c++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    mdio_i = 1;
    chk(seen, "R5 R6 done reached", 64'(seen), 64'd1);
    chk(!busy && !mdio_oe && !mdc, "R8 idle after done", {busy, mdio_oe, mdc}, 64'd0);
    chk(timeout == exp_to, "R7 timeout flag", 64'(timeout), 64'(exp_to));
    if (rd && !exp_to) last_rd = rdv;
    chk(rd_data == last_rd, rd ? (exp_to ? "R7 rd_data kept" : "R6 read data") : "R5 rd_data kept",
        64'(rd_data), 64'(last_rd));
    @(negedge clk);
    chk(!done, "R10 done one cycle", 64'(done), 64'd0);
    if (poke) begin
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (busy || done) extra = 1;
      end
      chk(!extra, "R9 start while busy ignored", 64'(extra), 64'd0);
    end
  endtask

  task automatic measure_mdc(input int d);
    time t0, t1, t2;
    @(posedge mdc); t0 = $time;
    @(negedge mdc); t1 = $time;
    @(posedge mdc); t2 = $time;
    chk((t1 - t0) == (d + 1) * 4, "R8 mdc high time", 64'(t1 - t0), 64'((d + 1) * 4));
    chk((t2 - t1) == (d + 1) * 4, "R8 mdc low time", 64'(t2 - t1), 64'((d + 1) * 4));
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    chk({busy, done, timeout, mdc, mdio_oe} == 5'b0, "R1 reset state",
        64'({busy, done, timeout, mdc, mdio_oe}), 64'd0);
    rst_n = 1;
    clk_div = 8'd2;
    fork
      run_txn(1'b0, 5'h1F, 5'h00, 16'hFFFF, 16'h0, 0, 0);
      measure_mdc(2);
    join
    clk_div = 8'd0;
    fork
      run_txn(1'b0, 5'h00, 5'h1F, 16'h0000, 16'h0, 0, 0);
      measure_mdc(0);
    join
    clk_div = 8'd1;
    run_txn(1'b1, 5'h05, 5'h0A, 16'h0, 16'hA5C3, 0, 0);
    run_txn(1'b1, 5'h11, 5'h02, 16'h0, 16'h1234, TMO - 1, 0);
    run_txn(1'b1, 5'h11, 5'h03, 16'h0, 16'h5555, TMO, 0);
    run_txn(1'b0, 5'h0C, 5'h15, 16'hBEEF, 16'h0, 0, 1);
    run_txn(1'b1, 5'h0C, 5'h16, 16'h0, 16'h8001, 2, 1);
    for (int n = 0; n < 20; n++) begin
      clk_div = 8'($urandom_range(0, 3));
      run_txn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
              $urandom_range(0, TMO), 1'($urandom_range(0, 3) == 0));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule